// File: doc/BRIEF.md
# PTP Event Timestamp Capture Buffer

This block holds the time at which a qualifying precision-time event packet crossed the port. It has one capture slot per traffic direction, receive and transmit by default. An external parser raises a one-cycle match pulse and supplies a sequence identifier and two class vectors, a parameter-class hit vector and a rule-class hit vector. If the direction's enable and masks accept the packet and the slot is empty, the slot stores the free-running 64-bit time that was present on the pulse cycle. The stored result is visible from the next cycle.

A filled slot stays locked. Later matches are dropped until software reads the result and releases the slot by writing a 1 to the valid bit of the status word. Turning a direction's enable on also discards any stale result held by that direction. All configuration and results go through one word-wide register port. Writes take effect on the clock edge. Reads are combinational from the read address.

Top module: `ptp_tscap_unit`

## Requirements
- R1: After reset every slot is empty and every result word reads 0. Each enable field reads 0. Each parameter-class mask reads 0x7FF and each rule-class mask reads 0x3FFF.
- R2: A capture happens on the edge that ends the cycle in which match is high, provided the slot is empty and the packet qualifies. From the next cycle the status word (offset 0) reads bit 16 = 1 and bits 15:0 = the sequence identifier from the pulse cycle. Offset 1 then reads bits 31:0 of the time seen in the pulse cycle, and offset 2 reads bits 63:32 of that time.
- R3: While a slot holds a result, match pulses on that direction leave the status word and both time words unchanged.
- R4: A write to offset 0 with bit 16 = 1 empties the slot, and status, low time and high time then read 0. A write to offset 0 with bit 16 = 0 has no effect. If a clear and a match fall in the same cycle, the slot ends empty.
- R5: The enable field (offset 3, bits 2:0) allows capture only when it holds 7. Any other value, 0 included, blocks capture.
- R6: A mask bit set to 1 excludes that class. A packet qualifies only if it has at least one parameter-class hit whose mask bit (offset 4, bits 10:0) is 0, and at least one rule-class hit whose mask bit (offset 5, bits 13:0) is 0. Masks that are all ones therefore select nothing.
- R7: Writing 7 to an enable field that does not already hold 7 empties that direction's slot. Writing 7 when the field already holds 7 leaves the held result in place.
- R8: Address bits above bit 2 select the direction (0 receive, 1 transmit), and directions never affect each other. Writes to offsets 1 and 2 are ignored. Offsets 6 and 7 read 0.
- R9: The enable, parameter-mask and rule-mask fields read back the value last written, truncated to 3, 11 and 14 bits and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | 64 | Free-running time counter |
| match_i | input | CH_N | One-cycle match pulse per direction |
| seq_i | input | 16*CH_N | Sequence identifier per direction |
| phit_i | input | 11*CH_N | Parameter-class hit vector per direction |
| rhit_i | input | 14*CH_N | Rule-class hit vector per direction |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | CH_W+3 | Write address: direction, then 3-bit offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | CH_W+3 | Read address: direction, then 3-bit offset |
| rd_data_o | output | 32 | Read data |

## Verification
The bench builds the block with its defaults: two directions and a 64-bit time source. With two directions, the direction bit of the address is live, so cross-talk between receive and transmit through either the write decode or the read mux can be seen. The bench moves the time input in random jumps as well as steady steps, so the upper time word changes between captures, and a swapped or stale word becomes visible.

// File: rtl/ptp_tscap_pkg.sv
package ptp_tscap_pkg;

    localparam int DW        = 32;
    localparam int TS_W      = 2 * DW;
    localparam int SEQ_W     = 16;
    localparam int PM_W      = 11;
    localparam int RM_W      = 14;
    localparam int EN_W      = 3;
    localparam int OFF_W     = 3;
    localparam int VALID_BIT = 16;

    localparam logic [EN_W-1:0] EN_ON  = '1;
    localparam logic [PM_W-1:0] PM_RST = '1;
    localparam logic [RM_W-1:0] RM_RST = '1;

    typedef enum logic [OFF_W-1:0] {
        OFF_STAT = 3'd0,
        OFF_TLO  = 3'd1,
        OFF_THI  = 3'd2,
        OFF_EN   = 3'd3,
        OFF_PM   = 3'd4,
        OFF_RM   = 3'd5
    } off_e;

    typedef struct packed {
        logic [EN_W-1:0] en;
        logic [PM_W-1:0] pm;
        logic [RM_W-1:0] rm;
    } cfg_t;

    typedef struct packed {
        logic             valid;
        logic [SEQ_W-1:0] seq;
        logic [TS_W-1:0]  ts;
    } slot_t;

    // The packet passes when capture is on and each class vector keeps an unmasked hit.
    function automatic logic qualifies(cfg_t c, logic [PM_W-1:0] ph, logic [RM_W-1:0] rh);
        return (c.en == EN_ON) && (|(ph & ~c.pm)) && (|(rh & ~c.rm));
    endfunction

    function automatic logic [DW-1:0] status_word(slot_t s);
        logic [DW-1:0] w;
        w = '0;
        w[VALID_BIT]   = s.valid;
        w[SEQ_W-1:0]   = s.seq;
        return w;
    endfunction

endpackage

// File: rtl/ptp_tscap_cfg.sv
module ptp_tscap_cfg
    import ptp_tscap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit_i,
    input  logic [OFF_W-1:0] wr_off_i,
    input  logic [RM_W-1:0]  wr_data_i,
    output cfg_t             cfg_o,
    output logic             arm_o
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.en <= '0;
            cfg_q.pm <= PM_RST;
            cfg_q.rm <= RM_RST;
        end else if (wr_hit_i) begin
            case (wr_off_i)
                OFF_EN:  cfg_q.en <= wr_data_i[EN_W-1:0];
                OFF_PM:  cfg_q.pm <= wr_data_i[PM_W-1:0];
                OFF_RM:  cfg_q.rm <= wr_data_i[RM_W-1:0];
                default: ;
            endcase
        end
    end

    // Turning capture on discards whatever the slot still holds.
    assign arm_o = wr_hit_i && (wr_off_i == OFF_EN)
                   && (wr_data_i[EN_W-1:0] == EN_ON) && (cfg_q.en != EN_ON);
    assign cfg_o = cfg_q;

endmodule

// File: rtl/ptp_tscap_slot.sv
module ptp_tscap_slot
    import ptp_tscap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take_i,
    input  logic             drop_i,
    input  logic [SEQ_W-1:0] seq_i,
    input  logic [TS_W-1:0]  time_i,
    output slot_t            slot_o
);

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (drop_i) begin
            slot_q <= '0;
        end else if (take_i && !slot_q.valid) begin
            slot_q.valid <= 1'b1;
            slot_q.seq   <= seq_i;
            slot_q.ts    <= time_i;
        end
    end

    assign slot_o = slot_q;

endmodule

// File: rtl/ptp_tscap_rdmux.sv
module ptp_tscap_rdmux
    import ptp_tscap_pkg::*;
(
    input  logic [OFF_W-1:0] off_i,
    input  cfg_t             cfg_i,
    input  slot_t            slot_i,
    output logic [DW-1:0]    data_o
);

    always_comb begin
        data_o = '0;
        case (off_i)
            OFF_STAT: data_o = status_word(slot_i);
            OFF_TLO:  data_o = slot_i.ts[DW-1:0];
            OFF_THI:  data_o = slot_i.ts[TS_W-1:DW];
            OFF_EN:   data_o[EN_W-1:0] = cfg_i.en;
            OFF_PM:   data_o[PM_W-1:0] = cfg_i.pm;
            OFF_RM:   data_o[RM_W-1:0] = cfg_i.rm;
            default:  data_o = '0;
        endcase
    end

endmodule

// File: rtl/ptp_tscap_unit.sv
module ptp_tscap_unit
    import ptp_tscap_pkg::*;
#(
    parameter  int CH_N = 2,
    localparam int CH_W = (CH_N > 1) ? $clog2(CH_N) : 1,
    localparam int AW   = CH_W + OFF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TS_W-1:0]       time_i,
    input  logic [CH_N-1:0]       match_i,
    input  logic [CH_N*SEQ_W-1:0] seq_i,
    input  logic [CH_N*PM_W-1:0]  phit_i,
    input  logic [CH_N*RM_W-1:0]  rhit_i,
    input  logic                  wr_en_i,
    input  logic [AW-1:0]         wr_addr_i,
    input  logic [DW-1:0]         wr_data_i,
    input  logic [AW-1:0]         rd_addr_i,
    output logic [DW-1:0]         rd_data_o
);

    logic [CH_W-1:0]        wr_ch, rd_ch;
    logic [OFF_W-1:0]       wr_off, rd_off;
    logic [CH_N-1:0]        slot_valid, clr_v, en_on_v;
    logic [CH_N*TS_W-1:0]   ts_flat;
    logic [CH_N*SEQ_W-1:0]  seq_flat;
    logic [DW-1:0]          ch_rd [CH_N];
    logic                   wr_data_unused;

    assign wr_ch  = wr_addr_i[AW-1 -: CH_W];
    assign wr_off = wr_addr_i[OFF_W-1:0];
    assign rd_ch  = rd_addr_i[AW-1 -: CH_W];
    assign rd_off = rd_addr_i[OFF_W-1:0];
    assign wr_data_unused = ^{wr_data_i[DW-1:VALID_BIT+1], wr_data_i[VALID_BIT-1:RM_W]};

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        logic  wr_hit, sw_clr, arm, ok;
        cfg_t  cfg;
        slot_t slot;

        assign wr_hit = wr_en_i && (wr_ch == CH_W'(c));
        assign sw_clr = wr_hit && (wr_off == OFF_STAT) && wr_data_i[VALID_BIT];

        ptp_tscap_cfg u_cfg (
            .clk       (clk),
            .rst       (rst),
            .wr_hit_i  (wr_hit),
            .wr_off_i  (wr_off),
            .wr_data_i (wr_data_i[RM_W-1:0]),
            .cfg_o     (cfg),
            .arm_o     (arm)
        );

        assign ok       = match_i[c] && qualifies(cfg, phit_i[c*PM_W +: PM_W],
                                                  rhit_i[c*RM_W +: RM_W]);
        assign clr_v[c] = sw_clr | arm;

        ptp_tscap_slot u_slot (
            .clk    (clk),
            .rst    (rst),
            .take_i (ok),
            .drop_i (clr_v[c]),
            .seq_i  (seq_i[c*SEQ_W +: SEQ_W]),
            .time_i (time_i),
            .slot_o (slot)
        );

        ptp_tscap_rdmux u_rd (
            .off_i  (rd_off),
            .cfg_i  (cfg),
            .slot_i (slot),
            .data_o (ch_rd[c])
        );

        assign slot_valid[c]              = slot.valid;
        assign en_on_v[c]                 = (cfg.en == EN_ON);
        assign ts_flat[c*TS_W +: TS_W]    = slot.ts;
        assign seq_flat[c*SEQ_W +: SEQ_W] = slot.seq;
    end

    always_comb begin
        rd_data_o = '0;
        for (int c = 0; c < CH_N; c++) begin
            if (rd_ch == CH_W'(c)) rd_data_o = ch_rd[c];
        end
    end

endmodule

// File: rtl/ptp_tscap_chk.sv
module ptp_tscap_chk
    import ptp_tscap_pkg::*;
#(
    parameter int CH_N = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic [CH_N-1:0]       valid_v,
    input logic [CH_N-1:0]       clr_v,
    input logic [CH_N-1:0]       en_on_v,
    input logic [CH_N*TS_W-1:0]  ts_flat,
    input logic [CH_N*SEQ_W-1:0] seq_flat
);

    for (genvar c = 0; c < CH_N; c++) begin : g_p
        // R3
        held_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (valid_v[c] && !clr_v[c]) |=> (valid_v[c]
                && $stable(ts_flat[c*TS_W +: TS_W]) && $stable(seq_flat[c*SEQ_W +: SEQ_W])));

        // R4
        clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
            clr_v[c] |=> !valid_v[c]);

        // R4
        empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !valid_v[c] |-> (ts_flat[c*TS_W +: TS_W] == '0 && seq_flat[c*SEQ_W +: SEQ_W] == '0));

        // R5
        gate_off_chk: assert property (@(posedge clk) disable iff (rst)
            (!en_on_v[c] && !valid_v[c]) |=> !valid_v[c]);

        // R7
        arm_only_when_off_chk: assert property (@(posedge clk) disable iff (rst)
            (en_on_v[c] && valid_v[c] && !clr_v[c]) |=> valid_v[c]);
    end

endmodule

bind ptp_tscap_unit ptp_tscap_chk #(.CH_N(CH_N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid_v  (slot_valid),
    .clr_v    (clr_v),
    .en_on_v  (en_on_v),
    .ts_flat  (ts_flat),
    .seq_flat (seq_flat)
);

// File: tb/tb_ptp_tscap_unit.sv
`timescale 1ns/100ps
module tb_ptp_tscap_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_i = 64'h0000_0001_FFFF_FF00;
    logic [1:0]  match_i = '0;
    logic [31:0] seq_i = '0;
    logic [21:0] phit_i = '0;
    logic [27:0] rhit_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // behavioural reference state, one entry per direction
    bit          m_valid [2];
    logic [15:0] m_seq   [2];
    logic [63:0] m_ts    [2];
    logic [2:0]  m_en    [2];
    logic [10:0] m_pm    [2];
    logic [13:0] m_rm    [2];

    ptp_tscap_unit dut (
        .clk(clk), .rst(rst), .time_i(time_i), .match_i(match_i), .seq_i(seq_i),
        .phit_i(phit_i), .rhit_i(rhit_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    always #4 clk = ~clk;

    task automatic model_step();
        for (int c = 0; c < 2; c++) begin
            if (rst) begin
                m_valid[c] = 0; m_seq[c] = '0; m_ts[c] = '0;
                m_en[c] = '0; m_pm[c] = 11'h7FF; m_rm[c] = 14'h3FFF;
            end else begin
                bit hit, clr, arm, ok;
                hit = wr_en_i && (wr_addr_i[3] == c[0]);
                clr = hit && wr_addr_i[2:0] == 3'd0 && wr_data_i[16];
                arm = hit && wr_addr_i[2:0] == 3'd3 && wr_data_i[2:0] == 3'd7 && m_en[c] != 3'd7;
                ok  = match_i[c] && m_en[c] == 3'd7
                      && ((phit_i[c*11 +: 11] & ~m_pm[c]) != 0)
                      && ((rhit_i[c*14 +: 14] & ~m_rm[c]) != 0);
                if (clr || arm) begin
                    m_valid[c] = 0; m_seq[c] = '0; m_ts[c] = '0;
                end else if (!m_valid[c] && ok) begin
                    m_valid[c] = 1; m_seq[c] = seq_i[c*16 +: 16]; m_ts[c] = time_i;
                end
                if (hit && wr_addr_i[2:0] == 3'd3) m_en[c] = wr_data_i[2:0];
                if (hit && wr_addr_i[2:0] == 3'd4) m_pm[c] = wr_data_i[10:0];
                if (hit && wr_addr_i[2:0] == 3'd5) m_rm[c] = wr_data_i[13:0];
            end
        end
    endtask

    function automatic logic [31:0] exp_rd(int c, int off);
        case (off)
            0: return {15'd0, m_valid[c], m_seq[c]};
            1: return m_ts[c][31:0];
            2: return m_ts[c][63:32];
            3: return {29'd0, m_en[c]};
            4: return {21'd0, m_pm[c]};
            5: return {18'd0, m_rm[c]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic compare_all();
        for (int c = 0; c < 2; c++) begin
            for (int off = 0; off < 8; off++) begin
                logic [31:0] e;
                rd_addr_i = {c[0], off[2:0]};
                #0.2;
                e = exp_rd(c, off);
                checks++;
                if (rd_data_o !== e) begin
                    errors++;
                    $display("FAIL %s ch%0d off%0d actual %h expected %h t=%0t",
                             (off >= 6) ? "R8" : (off >= 3) ? "R9" : cur_req,
                             c, off, rd_data_o, e, $time);
                end
            end
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        match_i = '0; wr_en_i = 1'b0;
        time_i = time_i + 64'd8;
    endtask

    task automatic wr(int c, int off, logic [31:0] d);
        wr_en_i = 1'b1; wr_addr_i = {c[0], off[2:0]}; wr_data_i = d;
        cyc();
    endtask

    task automatic pulse(int c, logic [15:0] s, logic [10:0] ph, logic [13:0] rh);
        match_i[c] = 1'b1; seq_i[c*16 +: 16] = s;
        phit_i[c*11 +: 11] = ph; rhit_i[c*14 +: 14] = rh;
        cyc();
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cur_req = "R1"; cyc();

        // R5: masks open but enable off, then a non-7 value
        cur_req = "R5";
        wr(0, 4, 0); wr(0, 5, 0); wr(1, 4, 0); wr(1, 5, 0);
        pulse(0, 16'h1111, 11'h001, 14'h0001);
        wr(0, 3, 3);
        pulse(0, 16'h1112, 11'h001, 14'h0001);

        // R2: enable and capture
        cur_req = "R2";
        wr(0, 3, 7);
        time_i = 64'hABCD_0123_FFFF_FFF0;
        pulse(0, 16'hBEEF, 11'h400, 14'h2000);
        cyc();

        // R3: held slot ignores new pulses
        cur_req = "R3";
        pulse(0, 16'h2222, 11'h7FF, 14'h3FFF);
        pulse(0, 16'h3333, 11'h001, 14'h0001);

        // R4: bit16 zero has no effect, then clear, then clear racing a pulse
        cur_req = "R4";
        wr(0, 0, 32'hFFFE_FFFF);
        wr(0, 0, 32'h0001_0000);
        match_i[0] = 1'b1; seq_i[15:0] = 16'h4444; phit_i[10:0] = 11'h1; rhit_i[13:0] = 14'h1;
        wr(0, 0, 32'h0001_0000);
        pulse(0, 16'h5555, 11'h1, 14'h1);

        // R7: rewriting 7 keeps, toggling off then on discards
        cur_req = "R7";
        wr(0, 3, 7);
        wr(0, 3, 0);
        wr(0, 3, 7);

        // R6: mask selection
        cur_req = "R6";
        wr(0, 4, 11'h7FE);
        pulse(0, 16'h6601, 11'h002, 14'h0001);
        pulse(0, 16'h6602, 11'h001, 14'h0001);
        wr(0, 0, 32'h0001_0000);
        wr(0, 4, 11'h7FF); wr(0, 5, 14'h3FFF);
        pulse(0, 16'h6603, 11'h7FF, 14'h3FFF);
        wr(0, 4, 0); wr(0, 5, 14'h3FFE);
        pulse(0, 16'h6604, 11'h7FF, 14'h0001);
        pulse(0, 16'h6605, 11'h7FF, 14'h0002);

        // R8: transmit direction independent, time words read-only
        cur_req = "R8";
        wr(1, 3, 7);
        time_i = 64'h1357_9BDF_0246_8ACE;
        pulse(1, 16'h7777, 11'h010, 14'h0100);
        wr(1, 1, 32'hDEAD_BEEF); wr(1, 2, 32'hCAFE_F00D);
        wr(0, 0, 32'h0001_0000);
        wr(1, 6, 32'hFFFF_FFFF); wr(1, 7, 32'hFFFF_FFFF);

        // R9: readback truncation
        cur_req = "R9";
        wr(1, 4, 32'hFFFF_F123); wr(1, 5, 32'hFFFF_9ABC); wr(1, 3, 32'hFFFF_FFF5);

        // mixed traffic
        cur_req = "R3";
        for (int i = 0; i < 3000; i++) begin
            for (int c = 0; c < 2; c++) begin
                if ($urandom_range(0, 3) == 0) begin
                    match_i[c] = 1'b1;
                    seq_i[c*16 +: 16]  = 16'($urandom);
                    phit_i[c*11 +: 11] = 11'($urandom) & 11'($urandom);
                    rhit_i[c*14 +: 14] = 14'($urandom) & 14'($urandom);
                end
            end
            if ($urandom_range(0, 9) == 0) begin
                wr_en_i = 1'b1;
                wr_addr_i = 4'($urandom);
                wr_data_i = $urandom;
                if (wr_addr_i[2:0] == 3'd3 && $urandom_range(0, 1) == 1) wr_data_i[2:0] = 3'd7;
            end
            if ($urandom_range(0, 50) == 0) time_i = {$urandom, $urandom};
            cyc();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule